// File: doc/BRIEF.md
# Supply Supervisor with Over-Voltage Lockout

This block decides when a switching controller may run, based on a digitised measurement of its own supply. An 8-bit supply code arrives every clock, scaled at 0.1 V per step (code 100 is 10.0 V). After an asynchronous power-on reset, the block waits for the internal reference to report itself stable. It then keeps the controller in a low-current standby until the supply has risen to the start level. While running it watches for two faults. A supply sag below the drop-out level sends it back to standby. A supply rise above the trip level shuts the controller off and holds it in a latched lockout. That lockout ends only when the supply falls far below the trip level.

Each of the four level comparisons is qualified by its own filter. A comparison acts only after it has held on a set number of consecutive samples (4 by default), so single-sample noise on the measurement cannot move the state machine. The controller enable, the regulator high/low select and the over-voltage flag are registered copies of the state, so each changes only on a clock edge.

States and transitions: POWER_ON_RESET (0) goes to STANDBY (1) once the reference is ready. STANDBY goes to RUN (2) on a qualified start level. RUN goes back to STANDBY on a qualified drop-out, or to LOCKOUT (3) on a qualified trip; the trip wins when both qualify together. LOCKOUT goes back to STANDBY on a qualified deep drop. The asynchronous reset sends any state to POWER_ON_RESET.

Top module: `supply_supervisor`

## Requirements
- R1: While `por_n` is low, and afterwards for as long as `ref_ready` stays low, `state_o` reads 0 (POWER_ON_RESET) and `ctrl_en`, `reg_hi` and `ov_flag` are all 0.
- R2: In POWER_ON_RESET, the first clock edge that samples `ref_ready` high moves the state to 1 (STANDBY).
- R3: In STANDBY, the state becomes 2 (RUN) on the 4th consecutive clock edge that samples `vsup_code` >= 100. A code of 99 never starts the block.
- R4: In RUN, the state becomes 1 (STANDBY) on the 4th consecutive edge that samples `vsup_code` < 80. A code of exactly 80 keeps the block running.
- R5: In RUN, the state becomes 3 (LOCKOUT) on the 4th consecutive edge that samples `vsup_code` > 140. A code of exactly 140 keeps the block running.
- R6: In LOCKOUT, only the 4th consecutive edge that samples `vsup_code` < 50 moves the state to 1 (STANDBY). Any code from 50 to 255 leaves the lockout in place.
- R7: A run of qualifying samples shorter than 4 that is broken by a single non-qualifying sample causes no transition, and the count restarts.
- R8: When a trip and a drop-out both become qualified on the same edge in RUN, the state becomes 3 (LOCKOUT), not STANDBY.
- R9: `ctrl_en` and `reg_hi` are 1 exactly one clock edge after the state is RUN and 0 otherwise. `ov_flag` is 1 exactly one edge after the state is LOCKOUT. `state_o` carries the encoding 0..3 given above.
- R10: Asserting `por_n` low at any time forces `state_o` to 0 and all three outputs to 0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ref_ready | input | 1 | Internal reference reports stable |
| vsup_code | input | 8 | Supply measurement, 0.1 V per LSB |
| ctrl_en | output | 1 | Controller enable, registered |
| reg_hi | output | 1 | Regulator mode select: 1 high level, 0 low level |
| ov_flag | output | 1 | Over-voltage latch flag |
| state_o | output | 2 | Current state: 0 reset, 1 standby, 2 run, 3 lockout |

## Verification
A wrong state appears on `state_o` at the edge where it is taken. It reaches `ctrl_en`, `reg_hi` and `ov_flag` one edge later. The bench therefore samples the state after exactly 3 and exactly 4 qualifying edges, and the outputs after the 5th. Miscounted filters, off-by-one thresholds and a lockout that releases on a shallow sag all show up as a state code that is wrong within a few cycles. A second instance with overlapping thresholds drives both fault conditions into qualification together, so that the trip-over-drop-out priority is visible at the ports.

// File: rtl/supsup_pkg.sv
package supsup_pkg;

    typedef enum logic [1:0] {
        ST_POR  = 2'd0,
        ST_STBY = 2'd1,
        ST_RUN  = 2'd2,
        ST_OVL  = 2'd3
    } sup_state_e;

    // Index of each filtered level condition in the condition vectors
    localparam int unsigned C_START  = 0;
    localparam int unsigned C_UV     = 1;
    localparam int unsigned C_OV     = 2;
    localparam int unsigned C_CLR    = 3;
    localparam int unsigned NUM_COND = 4;

endpackage

// File: rtl/supsup_levels.sv
module supsup_levels
    import supsup_pkg::*;
#(
    parameter int unsigned CODE_W     = 8,
    parameter int unsigned START_CODE = 100,
    parameter int unsigned UV_CODE    = 80,
    parameter int unsigned OV_CODE    = 140,
    parameter int unsigned CLR_CODE   = 50
) (
    input  logic [CODE_W-1:0]   code,
    output logic [NUM_COND-1:0] raw
);
    localparam logic [CODE_W-1:0] START_L = CODE_W'(START_CODE);
    localparam logic [CODE_W-1:0] UV_L    = CODE_W'(UV_CODE);
    localparam logic [CODE_W-1:0] OV_L    = CODE_W'(OV_CODE);
    localparam logic [CODE_W-1:0] CLR_L   = CODE_W'(CLR_CODE);

    always_comb begin
        raw          = '0;
        raw[C_START] = (code >= START_L);
        raw[C_UV]    = (code <  UV_L);
        raw[C_OV]    = (code >  OV_L);
        raw[C_CLR]   = (code <  CLR_L);
    end
endmodule

// File: rtl/supsup_filter.sv
module supsup_filter
    import supsup_pkg::*;
#(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic [NUM_COND-1:0] raw,
    output logic [NUM_COND-1:0] qual
);
    localparam int unsigned       CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(FILT_LEN - 1);

    for (genvar gi = 0; gi < NUM_COND; gi++) begin : g_cond
        logic [CNT_W-1:0] run_cnt;

        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                run_cnt <= '0;
            end else if (!raw[gi]) begin
                run_cnt <= '0;
            end else if (run_cnt != LAST) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end

        // Qualified on the sample that completes the run
        assign qual[gi] = raw[gi] && (run_cnt == LAST);
    end
endmodule

// File: rtl/supsup_fsm.sv
module supsup_fsm
    import supsup_pkg::*;
(
    input  logic                clk,
    input  logic                por_n,
    input  logic                ref_ready,
    input  logic [NUM_COND-1:0] qual,
    output sup_state_e          state
);
    sup_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_POR:  if (ref_ready)      state_nx = ST_STBY;
            ST_STBY: if (qual[C_START])  state_nx = ST_RUN;
            ST_RUN: begin
                if (qual[C_OV])          state_nx = ST_OVL;
                else if (qual[C_UV])     state_nx = ST_STBY;
            end
            ST_OVL:  if (qual[C_CLR])    state_nx = ST_STBY;
            default:                     state_nx = ST_POR;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_POR;
        else        state <= state_nx;
    end
endmodule

// File: rtl/supsup_outs.sv
module supsup_outs
    import supsup_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  sup_state_e state,
    output logic       ctrl_en,
    output logic       reg_hi,
    output logic       ov_flag
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctrl_en <= 1'b0;
            reg_hi  <= 1'b0;
            ov_flag <= 1'b0;
        end else begin
            ctrl_en <= (state == ST_RUN);
            reg_hi  <= (state == ST_RUN);
            ov_flag <= (state == ST_OVL);
        end
    end
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
    import supsup_pkg::*;
#(
    parameter int unsigned CODE_W     = 8,
    parameter int unsigned START_CODE = 100,
    parameter int unsigned UV_CODE    = 80,
    parameter int unsigned OV_CODE    = 140,
    parameter int unsigned CLR_CODE   = 50,
    parameter int unsigned FILT_LEN   = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ref_ready,
    input  logic [CODE_W-1:0] vsup_code,
    output logic              ctrl_en,
    output logic              reg_hi,
    output logic              ov_flag,
    output logic [1:0]        state_o
);
    logic [NUM_COND-1:0] raw;
    logic [NUM_COND-1:0] qual;
    sup_state_e          state;

    supsup_levels #(
        .CODE_W     (CODE_W),
        .START_CODE (START_CODE),
        .UV_CODE    (UV_CODE),
        .OV_CODE    (OV_CODE),
        .CLR_CODE   (CLR_CODE)
    ) u_levels (
        .code (vsup_code),
        .raw  (raw)
    );

    supsup_filter #(
        .FILT_LEN (FILT_LEN)
    ) u_filter (
        .clk   (clk),
        .por_n (por_n),
        .raw   (raw),
        .qual  (qual)
    );

    supsup_fsm u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .ref_ready (ref_ready),
        .qual      (qual),
        .state     (state)
    );

    supsup_outs u_outs (
        .clk     (clk),
        .por_n   (por_n),
        .state   (state),
        .ctrl_en (ctrl_en),
        .reg_hi  (reg_hi),
        .ov_flag (ov_flag)
    );

    assign state_o = state;
endmodule

// File: rtl/supply_supervisor_chk.sv
module supply_supervisor_chk #(
    parameter int unsigned CODE_W     = 8,
    parameter int unsigned START_CODE = 100,
    parameter int unsigned UV_CODE    = 80,
    parameter int unsigned OV_CODE    = 140,
    parameter int unsigned CLR_CODE   = 50
) (
    input logic              clk,
    input logic              por_n,
    input logic              ref_ready,
    input logic [CODE_W-1:0] vsup_code,
    input logic              ctrl_en,
    input logic              reg_hi,
    input logic              ov_flag,
    input logic [1:0]        state_o
);
    localparam logic [CODE_W-1:0] START_L = CODE_W'(START_CODE);
    localparam logic [CODE_W-1:0] UV_L    = CODE_W'(UV_CODE);
    localparam logic [CODE_W-1:0] OV_L    = CODE_W'(OV_CODE);
    localparam logic [CODE_W-1:0] CLR_L   = CODE_W'(CLR_CODE);

    p_por_hold_r1: assert property (@(posedge clk) disable iff (!por_n)
        (state_o == 2'd0 && !ref_ready) |=> (state_o == 2'd0));

    p_por_exit_r2: assert property (@(posedge clk) disable iff (!por_n)
        (state_o == 2'd0 && ref_ready) |=> (state_o == 2'd1));

    p_no_start_r3: assert property (@(posedge clk) disable iff (!por_n)
        (state_o == 2'd1 && vsup_code < START_L) |=> (state_o == 2'd1));

    p_run_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
        (state_o == 2'd2 && vsup_code >= UV_L && vsup_code <= OV_L)
        |=> (state_o == 2'd2));

    p_ovl_entry_r5: assert property (@(posedge clk) disable iff (!por_n)
        (state_o != 2'd3) |=> (state_o != 2'd3 || $past(state_o) == 2'd2));

    p_ovl_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
        (state_o == 2'd3 && vsup_code >= CLR_L) |=> (state_o == 2'd3));

    p_ctrl_follow_r9: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> (ctrl_en == ($past(state_o) == 2'd2)));

    p_reg_follow_r9: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> (reg_hi == ($past(state_o) == 2'd2)));

    p_ovflag_follow_r9: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> (ov_flag == ($past(state_o) == 2'd3)));

    // R10: with reset held, everything reads zero away from the clock edge
    always @(negedge clk) begin
        if (!por_n) begin
            p_reset_zero_r10: assert (state_o == 2'd0 && !ctrl_en && !reg_hi && !ov_flag);
        end
    end
endmodule

bind supply_supervisor supply_supervisor_chk #(
    .CODE_W     (CODE_W),
    .START_CODE (START_CODE),
    .UV_CODE    (UV_CODE),
    .OV_CODE    (OV_CODE),
    .CLR_CODE   (CLR_CODE)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .ref_ready (ref_ready),
    .vsup_code (vsup_code),
    .ctrl_en   (ctrl_en),
    .reg_hi    (reg_hi),
    .ov_flag   (ov_flag),
    .state_o   (state_o)
);

// File: tb/supply_supervisor_test.sv
module supply_supervisor_test;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ref_ready = 1'b0;
    logic [7:0] vcode = 8'd0;
    logic [7:0] vcode2 = 8'd0;

    logic       ctrl_en, reg_hi, ov_flag;
    logic [1:0] state_o;
    logic       p_ctrl, p_reg, p_ov;
    logic [1:0] p_state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    supply_supervisor uut (
        .clk (clk), .por_n (por_n), .ref_ready (ref_ready), .vsup_code (vcode),
        .ctrl_en (ctrl_en), .reg_hi (reg_hi), .ov_flag (ov_flag), .state_o (state_o)
    );

    // Drop-out level set above the trip level so both faults qualify together
    supply_supervisor #(.UV_CODE (200)) uut_prio (
        .clk (clk), .por_n (por_n), .ref_ready (ref_ready), .vsup_code (vcode2),
        .ctrl_en (p_ctrl), .reg_hi (p_reg), .ov_flag (p_ov), .state_o (p_state)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        step(1);
        check("R1 state in reset", state_o, 0);
        check("R1 ctrl_en in reset", ctrl_en, 0);
        check("R1 reg_hi in reset", reg_hi, 0);
        check("R1 ov_flag in reset", ov_flag, 0);
        por_n = 1'b1;
        vcode = 8'd120;
        step(6);
        check("R1 waits for reference", state_o, 0);
        check("R1 ctrl_en while waiting", ctrl_en, 0);
        vcode = 8'd0;
        ref_ready = 1'b1;
        step(1);
        check("R2 reference ready -> standby", state_o, 1);
        check("R2 prio instance standby", p_state, 1);
        step(1);
        check("R9 reg_hi low in standby", reg_hi, 0);
    endtask

    task automatic t_startup();
        vcode = 8'd99;
        step(8);
        check("R3 code 99 stays standby", state_o, 1);
        vcode = 8'd100;
        step(3);
        check("R7 three samples not enough", state_o, 1);
        step(1);
        check("R3 fourth sample -> run", state_o, 2);
        check("R9 ctrl_en lags state", ctrl_en, 0);
        step(1);
        check("R9 ctrl_en in run", ctrl_en, 1);
        check("R9 reg_hi in run", reg_hi, 1);
    endtask

    task automatic t_undervolt();
        vcode = 8'd120;
        step(2);
        for (int k = 0; k < 2; k++) begin
            vcode = 8'd79;
            step(3);
            vcode = 8'd85;
            step(1);
        end
        check("R7 broken drop-out runs ignored", state_o, 2);
        check("R7 ctrl_en kept", ctrl_en, 1);
        vcode = 8'd80;
        step(6);
        check("R4 code 80 keeps running", state_o, 2);
        vcode = 8'd79;
        step(3);
        check("R4 three samples below not enough", state_o, 2);
        step(1);
        check("R4 drop-out -> standby", state_o, 1);
        step(1);
        check("R9 ctrl_en off after drop-out", ctrl_en, 0);
        check("R9 reg_hi low after drop-out", reg_hi, 0);
        vcode = 8'd120;
        step(5);
        check("R3 restart -> run", state_o, 2);
        check("R9 ctrl_en on after restart", ctrl_en, 1);
    endtask

    task automatic t_overvolt();
        vcode = 8'd140;
        step(6);
        check("R5 code 140 keeps running", state_o, 2);
        vcode = 8'd141;
        step(3);
        check("R5 three samples above not enough", state_o, 2);
        step(1);
        check("R5 trip -> lockout", state_o, 3);
        step(1);
        check("R9 ov_flag set", ov_flag, 1);
        check("R9 ctrl_en off in lockout", ctrl_en, 0);
        check("R9 reg_hi low in lockout", reg_hi, 0);
        vcode = 8'd90;
        step(6);
        check("R6 code 90 holds lockout", state_o, 3);
        vcode = 8'd50;
        step(6);
        check("R6 code 50 holds lockout", state_o, 3);
        vcode = 8'd150;
        step(6);
        check("R6 code 150 holds lockout", state_o, 3);
        check("R6 ov_flag held", ov_flag, 1);
        vcode = 8'd49;
        step(3);
        check("R6 three samples below not enough", state_o, 3);
        step(1);
        check("R6 deep drop -> standby", state_o, 1);
        step(1);
        check("R9 ov_flag cleared", ov_flag, 0);
        step(4);
        check("R3 code 49 does not start", state_o, 1);
    endtask

    task automatic t_priority();
        vcode2 = 8'd150;
        step(4);
        check("R8 prio instance enters run", p_state, 2);
        step(1);
        check("R8 trip wins over drop-out", p_state, 3);
        step(1);
        check("R8 prio ov_flag", p_ov, 1);
    endtask

    task automatic t_async_reset();
        vcode = 8'd120;
        step(5);
        check("R3 run before reset", state_o, 2);
        check("R9 ctrl_en before reset", ctrl_en, 1);
        #2 por_n = 1'b0;
        #1;
        check("R10 state cleared at once", state_o, 0);
        check("R10 ctrl_en cleared at once", ctrl_en, 0);
        check("R10 reg_hi cleared at once", reg_hi, 0);
        step(1);
        por_n = 1'b1;
        step(1);
        check("R2 standby after reset release", state_o, 1);
    endtask

    initial begin
        t_reset();
        t_startup();
        t_undervolt();
        t_overvolt();
        t_priority();
        t_async_reset();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule